// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This peripheral sits on a simple word-addressed register bus and keeps a free-running up-counter that advances once every 2^n clocks, where n is a field in its control word. The counter climbs to a programmable limit, folds back to zero on the next count, and pulses an output for one clock at each fold. Software gets a steady periodic event from this pulse and never has to poll the counter.

A second path measures time. An asynchronous event pin passes through a flip-flop synchroniser. On each rising edge of the synchronised signal, the current counter value is copied into a capture word. Because the copy is made in hardware, the delay before software services the event does not change the timestamp it reads. Writing a new limit also restarts the count, so a new period begins at a known point.

The bus has write enable, read enable, address, write data and registered read data. Address bits [3:2] choose one of four words. Word 0 holds the limit and is read/write. Word 1 is the counter and is read-only. Word 2 is the control word and is read/write. Word 3 is the capture value and is read-only.

Top module: `capture_compare_timer`

## Requirements
- R1: While `rstN` is low at a clock edge (synchronous, active low), the limit, control word, counter, prescaler, capture value, read data and `matchEvent` are all cleared. After reset, each of the four words reads 0.
- R2: `busAddr[3:2]` selects the word: 0 is the limit, 1 is the counter, 2 is the control word and 3 is the capture value. All other address bits are ignored. Words 0 and 2 read back exactly the last value written to them.
- R3: A write to word 0 loads the limit. It also clears the counter and the prescaler at the clock edge after the write edge, whether or not counting is enabled. Writes to words 1, 2 and 3 leave the counter value unchanged.
- R4: Writes to word 1 (counter) and word 3 (capture) have no effect on any stored value.
- R5: Control bit 0 enables counting. While it is 0, the counter holds its value and the prescaler is held at zero.
- R6: Control bits [7:4] hold an exponent n. Once counting is enabled from a cleared state at edge E, the counter holds floor(m / 2^n) mod (limit+1) after edge E+m.
- R7: A count step taken while the counter equals the limit loads 0 instead of incrementing. `matchEvent` is high for exactly the clock that follows that step, so it pulses every (limit+1)·2^n enabled clocks.
- R8: `extEvent` passes through two synchroniser flops. When `extEvent` rises just after edge K, the capture word takes the counter value held after edge K+2, and it updates at edge K+3. Capture works whether or not counting is enabled.
- R9: Only a rising edge of the synchronised event captures. Holding `extEvent` high, or letting it fall, leaves the capture word unchanged.
- R10: Read data is registered. When `busRdEn` is high at an edge, `busRdData` shows the selected word's value from before that edge. At any edge with no read, `busRdData` keeps its value. When `busWrEn` and `busRdEn` are both high, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W (4) | Byte address; bits [3:2] select the word |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Registered read data |
| extEvent | input | 1 | Asynchronous capture trigger |
| matchEvent | output | 1 | One-clock pulse when the counter folds back to zero |

## Verification
The assertions assume that reset is held across at least one clock edge. They also assume that the bus strobes and address are stable around each rising edge. The bench changes every input, `extEvent` included, on the falling clock edge, so each one is settled well before the next rising edge. The capture latency checks therefore see no metastability window and can give an exact expected value. Each pulse on `extEvent` is held high and low for several clocks, so every rising edge reaches the synchroniser output and is detected.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRESC_SEL_W = 4;

  typedef enum logic [1:0] {
    REG_LIMIT = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CAPT  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic                   clearCount;
    logic                   captureNow;
    logic                   countEnable;
    logic [PRESC_SEL_W-1:0] prescSel;
  } tmrStrobes_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strobes,
  input  logic [DATA_W-1:0] limitVal,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] captureVal,
  output logic              matchEvent
);
  localparam int PRESC_W = (1 << PRESC_SEL_W) - 1;

  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescLimit;
  logic               countTick;

  assign prescLimit = PRESC_W'((32'd1 << strobes.prescSel) - 32'd1);
  assign countTick  = strobes.countEnable && (prescCnt == prescLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt   <= '0;
      countVal   <= '0;
      captureVal <= '0;
      matchEvent <= 1'b0;
    end else begin
      matchEvent <= 1'b0;
      if (strobes.clearCount || !strobes.countEnable || countTick)
        prescCnt <= '0;
      else
        prescCnt <= prescCnt + 1'b1;

      if (strobes.clearCount) begin
        countVal <= '0;
      end else if (countTick) begin
        if (countVal == limitVal) begin
          countVal   <= '0;
          matchEvent <= 1'b1;
        end else begin
          countVal <= countVal + 1'b1;
        end
      end

      if (strobes.captureNow)
        captureVal <= countVal;
    end
  end

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCount |=> countVal == '0);
  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.countEnable && !strobes.clearCount) |=> $stable(countVal));
  assert_match_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    matchEvent |-> countVal == '0);
  assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureNow |=> captureVal == $past(countVal));
  assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureNow |=> $stable(captureVal));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              extEvent,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] captureVal,
  output tmrStrobes_t       strobes,
  output logic [DATA_W-1:0] limitVal
);
  localparam int SEL_LO = 2;
  localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'(3 << SEL_LO);

  regSel_e                regSel;
  logic [DATA_W-1:0]      ctrlReg;
  logic                   clearReq;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   evtPrev;
  logic                   unusedAddr;

  assign regSel     = regSel_e'(busAddr[SEL_LO+1:SEL_LO]);
  assign unusedAddr = ^(busAddr & ~SEL_MASK);

  always_ff @(posedge clk) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= extEvent;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) syncChain[i] <= 1'b0;
      else       syncChain[i] <= syncChain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) evtPrev <= 1'b0;
    else       evtPrev <= syncChain[SYNC_STAGES-1];
  end

  always_comb begin
    strobes.clearCount  = clearReq;
    strobes.captureNow  = syncChain[SYNC_STAGES-1] & ~evtPrev;
    strobes.countEnable = ctrlReg[0];
    strobes.prescSel    = ctrlReg[4 +: PRESC_SEL_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      limitVal  <= '0;
      clearReq  <= 1'b0;
      busRdData <= '0;
    end else begin
      clearReq <= 1'b0;
      if (busWrEn) begin
        case (regSel)
          REG_LIMIT: begin
            limitVal <= busWrData;
            clearReq <= 1'b1;
          end
          REG_CTRL: ctrlReg <= busWrData;
          default: ;
        endcase
      end else if (busRdEn) begin
        case (regSel)
          REG_LIMIT: busRdData <= limitVal;
          REG_COUNT: busRdData <= countVal;
          REG_CTRL:  busRdData <= ctrlReg;
          default:   busRdData <= captureVal;
        endcase
      end
    end
  end

  assert_limit_write_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && regSel == REG_LIMIT) |=> strobes.clearCount);
  assert_other_write_no_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && regSel != REG_LIMIT) |=> !strobes.clearCount);
  assert_count_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && regSel == REG_COUNT) |=> busRdData == $past(countVal));
  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdEn || busWrEn) |=> $stable(busRdData));
endmodule

// File: rtl/capture_compare_timer.sv
module capture_compare_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              extEvent,
  output logic              matchEvent
);
  tmrStrobes_t       strobes;
  logic [DATA_W-1:0] limitVal;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] captureVal;

  tmr_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .extEvent(extEvent), .countVal(countVal), .captureVal(captureVal),
    .strobes(strobes), .limitVal(limitVal)
  );

  tmr_datapath #(.DATA_W(DATA_W)) uDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .limitVal(limitVal),
    .countVal(countVal), .captureVal(captureVal), .matchEvent(matchEvent)
  );
endmodule

// File: tb/tb_capture_compare_timer.sv
module tb_capture_compare_timer;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic extEvent = 1'b0;
  logic matchEvent;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  capture_compare_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .extEvent(extEvent), .matchEvent(matchEvent)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    v = busRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] lim;
    int period;
    int limits[5] = '{0, 1, 2, 3, 5};

    repeat (3) @(negedge clk);
    check("R1 read data in reset", busRdData, 0);
    check("R1 match in reset", 32'(matchEvent), 0);
    rstN = 1'b1;
    for (int w = 0; w < 4; w++) begin
      busRead(4'(w * 4), v);
      check("R1 word after reset", v, 0);
    end

    // R2: word select and readback, low address bits ignored
    busWrite(4'h0, 32'h1234);
    busWrite(4'h8, 32'h000000A0);
    busRead(4'h1, v);  check("R2 limit readback", v, 32'h1234);
    busRead(4'hB, v);  check("R2 control readback", v, 32'hA0);
    busRead(4'h4, v);  check("R2 counter word", v, 0);

    // Count to a known value, then freeze (R5)
    busWrite(4'h8, 0);
    busWrite(4'h0, 1000);
    busWrite(4'h8, 1);
    repeat (5) @(negedge clk);
    busWrite(4'h8, 0);
    busRead(4'h4, v);  check("R5 counted value", v, 7);
    repeat (10) @(negedge clk);
    busRead(4'h4, v);  check("R5 frozen when disabled", v, 7);

    // R8: capture while frozen
    @(negedge clk); extEvent = 1'b1;
    repeat (4) @(negedge clk); extEvent = 1'b0;
    repeat (4) @(negedge clk);
    busRead(4'hC, v);  check("R8 capture frozen count", v, 7);

    // R4: read-only words ignore writes
    busWrite(4'h4, 99);
    busWrite(4'hC, 55);
    busRead(4'h4, v);  check("R4 counter not written", v, 7);
    busRead(4'hC, v);  check("R4 capture not written", v, 7);
    busWrite(4'h8, 0);
    busRead(4'h4, v);  check("R3 control write keeps count", v, 7);

    // R3: limit write clears counter
    busWrite(4'h0, 1000);
    busRead(4'h4, v);  check("R3 count cleared", v, 0);
    busRead(4'h0, v);  check("R3 limit loaded", v, 1000);

    // R8 latency, R9 level/falling, R10 hold
    busWrite(4'h8, 1);
    repeat (3) @(negedge clk);
    extEvent = 1'b1;
    repeat (20) @(negedge clk);
    busRead(4'hC, v);  check("R8 capture latency", v, 5);
    extEvent = 1'b0;
    repeat (5) @(negedge clk);
    busRead(4'hC, v);  check("R9 no recapture", v, 5);
    repeat (6) @(negedge clk);
    check("R10 read data held", busRdData, 5);

    // R10: write wins over read
    busRead(4'h8, v);  check("R10 control read", v, 1);
    @(negedge clk);
    busWrEn = 1'b1; busRdEn = 1'b1; busAddr = 4'h0; busWrData = 500;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
    check("R10 read dropped on write", busRdData, 1);
    busRead(4'h0, v);  check("R3 simultaneous write taken", v, 500);

    // R6/R7 sweep over prescale and limit
    for (int n = 0; n < 4; n++) begin
      for (int li = 0; li < 5; li++) begin
        lim = 32'(limits[li]);
        busWrite(4'h8, 0);
        busWrite(4'h0, lim);
        @(negedge clk);
        busWrEn = 1'b1; busAddr = 4'h8; busWrData = 32'((n << 4) | 1); busRdEn = 1'b1;
        @(negedge clk);
        busWrEn = 1'b0; busAddr = 4'h4;
        period = (int'(lim) + 1) << n;
        for (int m = 1; m <= 2 * period + 2; m++) begin
          @(negedge clk);
          check("R7 match pulse", 32'(matchEvent), 32'((m % period) == 0));
          check("R6 prescaled count", busRdData, 32'(((m - 1) >> n) % (int'(lim) + 1)));
        end
        busRdEn = 1'b0;
      end
    end

    // R1: reset during operation
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R1 match after reset", 32'(matchEvent), 0);
    busRead(4'h8, v);  check("R1 control cleared", v, 0);
    busRead(4'h0, v);  check("R1 limit cleared", v, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule